// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the serial side of a single-PHY management port. The master moves one bit per MDC rising edge. The bit clock is not sampled inside this block. Instead, two one-cycle strobes report what the master does on each edge:

- `mdc_wr_tick` means the master drives a bit, given on `mdio_i`.
- `mdc_rd_tick` means the master samples the line.

The slave waits through a preamble of ones and recognises the start pattern. It then gathers a 12-bit header: a 2-bit opcode, a 5-bit PHY address that is ignored, and a 5-bit register address. After the header it either serialises a register value back to the master or collects a 16-bit write value.

The register file sits behind two plain strobed channels, and neither has back-pressure.

- **Read channel.** `reg_rd_req` pulses for one cycle with `reg_rd_addr`. The register file must present `reg_rd_data` combinationally in that same cycle, and the slave captures it at the clock edge that ends the cycle.
- **Write channel.** `reg_wr_en` pulses for one cycle with `reg_wr_addr` and `reg_wr_data`. The register file must accept the write in that cycle, because no ready signal exists.

Two rules apply to the master:

- The two tick strobes are never asserted in the same cycle. If both are asserted, the read tick wins.
- The two ticks may arrive in consecutive clock cycles.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the frame state machine in idle, clears its bit counter and accumulator, and drives `mdio_o`, `mdio_oe` and `reg_wr_en` low. This holds even in the middle of a frame.
- R2: In idle, a write tick with `mdio_i`=1 keeps the slave idle, and the first 0 moves it to a start-wait state. In start-wait, further 0s keep it waiting, and a 1 begins header collection.
- R3: The header is exactly 12 bits, MSB first: opcode (2 bits), PHY address (5 bits, ignored: any value is accepted), register address (5 bits).
- R4: Opcode 2'b10 is a read. In the cycle of the write tick that carries the last header bit, `reg_rd_req` is high for one cycle with `reg_rd_addr` equal to the header's register address, and the returned data is captured.
- R5: After a read header, the first read tick drives a turnaround bit of 0 with `mdio_oe` high. The next 16 read ticks each drive one captured data bit, MSB first, with `mdio_oe` high. `mdio_o`/`mdio_oe` change only on a tick, in the cycle after it.
- R6: `mdio_oe` is high only for the read turnaround bit and the read data bits. It stays high after the last data bit and drops on the next tick of either kind.
- R7: Opcode 2'b01 is a write. Two turnaround bits of any value are skipped, and then 16 data bits are collected MSB first. In the cycle after the tick of the last data bit, `reg_wr_en` is high for exactly one cycle with the saved register address and the collected value.
- R8: Opcodes 2'b00 and 2'b11 return the slave to idle with no register read or write.
- R9: A read tick while the slave is not in the read turnaround or read data phase drives `mdio_o`=0 with `mdio_oe`=0 and returns the slave to idle, abandoning any frame in progress.
- R10: A write tick during the read turnaround or read data phase abandons the read: the slave returns to idle and `mdio_oe` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mdc_wr_tick | input | 1 | One-cycle strobe: master drives a bit on this MDC edge |
| mdio_i | input | 1 | Bit value driven by the master |
| mdc_rd_tick | input | 1 | One-cycle strobe: master samples the line on this MDC edge |
| mdio_o | output | 1 | Bit driven by the slave |
| mdio_oe | output | 1 | Slave output enable for the shared data line |
| reg_rd_req | output | 1 | One-cycle register read request |
| reg_rd_addr | output | 5 | Register address of the read request |
| reg_rd_data | input | 16 | Register value, returned in the request cycle |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 5 | Register address of the write |
| reg_wr_data | output | 16 | Value to write |

## Verification
A corrupted state or bit count shows up at the ports within one frame:

- a misplaced turnaround shifts every read bit by one position, or leaves `mdio_oe` low where it should be high;
- a miscounted header or data phase moves the `reg_rd_req` or `reg_wr_en` pulse to the wrong tick, with a wrong address or value.

An abort path that fails to return to idle is exposed by the next frame, which then decodes garbage. For that reason every abort scenario is followed at once by a clean frame whose result is checked.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

  localparam int OP_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_TA_RD,
    ST_TA_WR,
    ST_RDATA,
    ST_WDATA
  } mdio_st_e;

  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mdio_shift_acc.sv
module mdio_shift_acc #(
  parameter int ACC_W  = 16,
  parameter int LOAD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift,
  input  logic              load,
  input  logic              bit_in,
  input  logic [LOAD_W-1:0] load_val,
  output logic [ACC_W-1:0]  acc,
  output logic [ACC_W-1:0]  acc_nxt
);

  // Shifted view, used by the decode of the bit arriving in this cycle.
  assign acc_nxt = {acc[ACC_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (load) begin
      acc <= ACC_W'(load_val);
    end else if (shift) begin
      acc <= acc_nxt;
    end
  end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_slv_pkg::*;
#(
  parameter int HDR_W  = 12,
  parameter int DATA_W = 16,
  parameter int WR_TA  = 2,
  parameter int CNT_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_tick,
  input  logic            rd_tick,
  input  logic            bit_in,
  input  logic [OP_W-1:0] hdr_op,
  output mdio_st_e        st,
  output logic            acc_clr,
  output logic            acc_shift,
  output logic            acc_load,
  output logic            rd_fire,
  output logic            addr_save,
  output logic            wr_done,
  output logic            tx_en,
  output logic            tx_data
);

  mdio_st_e         st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             last;

  assign last = (cnt == CNT_W'(1));

  always_comb begin
    st_n      = st;
    cnt_n     = cnt;
    acc_clr   = 1'b0;
    acc_shift = 1'b0;
    acc_load  = 1'b0;
    rd_fire   = 1'b0;
    addr_save = 1'b0;
    wr_done   = 1'b0;
    tx_en     = 1'b0;
    tx_data   = 1'b0;
    if (rd_tick) begin
      unique case (st)
        ST_TA_RD: begin
          tx_en = 1'b1;
          st_n  = ST_RDATA;
          cnt_n = CNT_W'(DATA_W);
        end
        ST_RDATA: begin
          tx_en     = 1'b1;
          tx_data   = 1'b1;
          acc_shift = 1'b1;
          cnt_n     = cnt - 1'b1;
          if (last) st_n = ST_IDLE;
        end
        default: begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      endcase
    end else if (wr_tick) begin
      unique case (st)
        ST_IDLE: begin
          if (!bit_in) st_n = ST_START;
        end
        ST_START: begin
          if (bit_in) begin
            st_n    = ST_HDR;
            cnt_n   = CNT_W'(HDR_W);
            acc_clr = 1'b1;
          end
        end
        ST_HDR: begin
          acc_shift = 1'b1;
          cnt_n     = cnt - 1'b1;
          if (last) begin
            if (hdr_op == OP_READ) begin
              rd_fire  = 1'b1;
              acc_load = 1'b1;
              st_n     = ST_TA_RD;
              cnt_n    = CNT_W'(1);
            end else if (hdr_op == OP_WRITE) begin
              addr_save = 1'b1;
              st_n      = ST_TA_WR;
              cnt_n     = CNT_W'(WR_TA);
            end else begin
              st_n  = ST_IDLE;
              cnt_n = '0;
            end
          end
        end
        ST_TA_WR: begin
          cnt_n = cnt - 1'b1;
          if (last) begin
            st_n  = ST_WDATA;
            cnt_n = CNT_W'(DATA_W);
          end
        end
        ST_WDATA: begin
          acc_shift = 1'b1;
          cnt_n     = cnt - 1'b1;
          if (last) begin
            wr_done = 1'b1;
            st_n    = ST_IDLE;
          end
        end
        default: begin
          // Master drove the line during a read phase: abandon the frame.
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

endmodule

// File: rtl/mdio_pin_drv.sv
module mdio_pin_drv (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tx_en,
  input  logic tx_bit,
  output logic mdio_o,
  output logic mdio_oe
);

  // The line is updated only on a master edge; any edge without a bit
  // to present releases it.
  always_ff @(posedge clk) begin
    if (rst) begin
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (tick) begin
      mdio_o  <= tx_en & tx_bit;
      mdio_oe <= tx_en;
    end
  end

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int WR_TA  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc_wr_tick,
  input  logic              mdio_i,
  input  logic              mdc_rd_tick,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              reg_rd_req,
  output logic [REG_AW-1:0] reg_rd_addr,
  input  logic [DATA_W-1:0] reg_rd_data,
  output logic              reg_wr_en,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data
);

  localparam int HDR_W = OP_W + PHY_AW + REG_AW;
  localparam int ACC_W = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(ACC_W + 1);

  mdio_st_e         fsm_st;
  logic             acc_clr, acc_shift, acc_load;
  logic             rd_fire, addr_save, wr_done;
  logic             tx_en, tx_data;
  logic [ACC_W-1:0] acc, acc_nxt;
  logic             tick_any;

  assign tick_any = mdc_wr_tick | mdc_rd_tick;

  mdio_frame_fsm #(
    .HDR_W (HDR_W),
    .DATA_W(DATA_W),
    .WR_TA (WR_TA),
    .CNT_W (CNT_W)
  ) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .wr_tick  (mdc_wr_tick),
    .rd_tick  (mdc_rd_tick),
    .bit_in   (mdio_i),
    .hdr_op   (acc_nxt[HDR_W-1 -: OP_W]),
    .st       (fsm_st),
    .acc_clr  (acc_clr),
    .acc_shift(acc_shift),
    .acc_load (acc_load),
    .rd_fire  (rd_fire),
    .addr_save(addr_save),
    .wr_done  (wr_done),
    .tx_en    (tx_en),
    .tx_data  (tx_data)
  );

  mdio_shift_acc #(
    .ACC_W (ACC_W),
    .LOAD_W(DATA_W)
  ) i_acc (
    .clk     (clk),
    .rst     (rst),
    .clr     (acc_clr),
    .shift   (acc_shift),
    .load    (acc_load),
    .bit_in  (mdio_i),
    .load_val(reg_rd_data),
    .acc     (acc),
    .acc_nxt (acc_nxt)
  );

  mdio_pin_drv i_pin (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_any),
    .tx_en  (tx_en),
    .tx_bit (tx_data & acc[DATA_W-1]),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
  );

  assign reg_rd_req  = rd_fire;
  assign reg_rd_addr = acc_nxt[REG_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_en <= wr_done;
      if (addr_save) reg_wr_addr <= acc_nxt[REG_AW-1:0];
      if (wr_done)   reg_wr_data <= acc_nxt[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk
  import mdio_slv_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     mdc_wr_tick,
  input logic     mdc_rd_tick,
  input logic     mdio_o,
  input logic     mdio_oe,
  input logic     reg_rd_req,
  input logic     reg_wr_en,
  input mdio_st_e fsm_st
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mdio_oe && !mdio_o && !reg_wr_en && fsm_st == ST_IDLE));

  a_r4_rdreq_on_wr_tick: assert property (@(posedge clk) disable iff (rst)
    reg_rd_req |-> mdc_wr_tick);

  a_r4_rdreq_enters_ta: assert property (@(posedge clk) disable iff (rst)
    reg_rd_req |=> fsm_st == ST_TA_RD);

  a_r5_line_holds_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !(mdc_wr_tick || mdc_rd_tick) |=> ($stable(mdio_oe) && $stable(mdio_o)));

  a_r7_wr_single_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);

  a_r7_wr_follows_tick: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $past(mdc_wr_tick));

  a_r9_rd_tick_outside_read: assert property (@(posedge clk) disable iff (rst)
    (mdc_rd_tick && fsm_st != ST_TA_RD && fsm_st != ST_RDATA)
      |=> (!mdio_oe && !mdio_o && fsm_st == ST_IDLE));

  a_r10_wr_tick_in_read: assert property (@(posedge clk) disable iff (rst)
    (mdc_wr_tick && !mdc_rd_tick && (fsm_st == ST_TA_RD || fsm_st == ST_RDATA))
      |=> (fsm_st == ST_IDLE && !mdio_oe));

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .mdc_wr_tick(mdc_wr_tick),
  .mdc_rd_tick(mdc_rd_tick),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .reg_rd_req (reg_rd_req),
  .reg_wr_en  (reg_wr_en),
  .fsm_st     (fsm_st)
);

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdc_wr_tick = 1'b0;
  logic        mdio_i = 1'b1;
  logic        mdc_rd_tick = 1'b0;
  logic        mdio_o, mdio_oe;
  logic        reg_rd_req, reg_wr_en;
  logic [4:0]  reg_rd_addr, reg_wr_addr;
  logic [15:0] reg_rd_data, reg_wr_data;

  logic [15:0] mem     [32];
  logic [15:0] exp_mem [32];
  int          n_chk = 0, n_fail = 0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [4:0]  last_rd_addr = '0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_slave i_mdio_mgmt_slave (
    .clk(clk), .rst(rst),
    .mdc_wr_tick(mdc_wr_tick), .mdio_i(mdio_i), .mdc_rd_tick(mdc_rd_tick),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .reg_rd_req(reg_rd_req), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
  );

  // Register file model answering the read channel combinationally.
  assign reg_rd_data = mem[reg_rd_addr];

  always @(posedge clk) begin
    if (reg_rd_req) begin
      rd_cnt       <= rd_cnt + 1;
      last_rd_addr <= reg_rd_addr;
    end
    if (reg_wr_en) begin
      wr_cnt           <= wr_cnt + 1;
      mem[reg_wr_addr] <= reg_wr_data;
    end
  end

  function automatic logic [15:0] init_val(input int i);
    return 16'(i * 16'h1357) ^ 16'hA5C3;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick_w(input logic b);
    @(negedge clk);
    mdio_i = b;
    mdc_wr_tick = 1'b1;
    @(negedge clk);
    mdc_wr_tick = 1'b0;
  endtask

  task automatic tick_r(output logic o, output logic oe);
    @(negedge clk);
    mdc_rd_tick = 1'b1;
    @(negedge clk);
    mdc_rd_tick = 1'b0;
    o  = mdio_o;
    oe = mdio_oe;
  endtask

  task automatic send_hdr(input int pre, input int zeros, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] ra);
    repeat (pre) tick_w(1'b1);
    tick_w(1'b0);
    repeat (zeros) tick_w(1'b0);
    tick_w(1'b1);
    for (int i = 1; i >= 0; i--) tick_w(op[i]);
    for (int i = 4; i >= 0; i--) tick_w(phy[i]);
    for (int i = 4; i >= 0; i--) tick_w(ra[i]);
  endtask

  task automatic do_read(input int pre, input int zeros, input logic [4:0] phy, input logic [4:0] ra);
    logic [15:0] got;
    logic        o, oe;
    int          rc0;
    bit          oe_all;
    rc0 = rd_cnt;
    send_hdr(pre, zeros, 2'b10, phy, ra);
    chk(rd_cnt == rc0 + 1, "R4 one read request", rd_cnt, rc0 + 1);
    chk(last_rd_addr == ra, "R4/R3 read address (PHY field ignored)", last_rd_addr, ra);
    tick_r(o, oe);
    chk(o == 1'b0 && oe == 1'b1, "R5 turnaround bit 0 driven", {o, oe}, 2'b01);
    got = '0;
    oe_all = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tick_r(o, oe);
      got = {got[14:0], o};
      if (!oe) oe_all = 1'b0;
    end
    chk(got == exp_mem[ra], "R5 read data MSB first", got, exp_mem[ra]);
    chk(oe_all, "R6 oe held through data bits", oe_all, 1);
    tick_w(1'b1);
    chk(mdio_oe == 1'b0, "R6 oe released on next tick", mdio_oe, 0);
  endtask

  task automatic do_write(input int pre, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] d, input logic [1:0] ta);
    int wc0;
    wc0 = wr_cnt;
    send_hdr(pre, 0, 2'b01, phy, ra);
    tick_w(ta[1]);
    tick_w(ta[0]);
    for (int i = 15; i >= 0; i--) begin
      tick_w(d[i]);
      if (i == 1) chk(wr_cnt == wc0, "R7 no early write strobe", wr_cnt, wc0);
    end
    chk(reg_wr_en == 1'b1, "R7 write strobe", reg_wr_en, 1);
    chk(reg_wr_addr == ra, "R7 write address", reg_wr_addr, ra);
    chk(reg_wr_data == d, "R7 write data", reg_wr_data, d);
    @(negedge clk);
    chk(reg_wr_en == 1'b0 && wr_cnt == wc0 + 1, "R7 single strobe", wr_cnt, wc0 + 1);
    exp_mem[ra] = d;
  endtask

  initial begin
    logic o, oe;
    int   rc0, wc0;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 32; i++) begin
      mem[i]     = init_val(i);
      exp_mem[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mdio_oe == 0 && mdio_o == 0 && reg_wr_en == 0 && reg_rd_req == 0,
        "R1 outputs in reset", {mdio_o, mdio_oe, reg_wr_en, reg_rd_req}, 0);
    rst = 1'b0;
    @(negedge clk);

    // Directed: long preamble, then a read.
    do_read(32, 0, 5'd1, 5'd2);
    // R2: extra zeros in start-wait are tolerated
    do_read(4, 3, 5'd31, 5'd17);
    // R2: preamble of ones alone issues nothing
    rc0 = rd_cnt; wc0 = wr_cnt;
    repeat (40) tick_w(1'b1);
    chk(rd_cnt == rc0 && wr_cnt == wc0, "R2 preamble idle", rd_cnt + wr_cnt, rc0 + wc0);
    // Write then read back.
    do_write(2, 5'd9, 5'd4, 16'hBEEF, 2'b10);
    do_read(1, 0, 5'd0, 5'd4);
    do_write(0, 5'd0, 5'd31, 16'h8001, 2'b01);
    do_read(0, 0, 5'd3, 5'd31);

    // R8: invalid opcodes do nothing, then the slave is idle.
    for (int k = 0; k < 2; k++) begin
      rc0 = rd_cnt; wc0 = wr_cnt;
      send_hdr(1, 0, (k == 0) ? 2'b00 : 2'b11, 5'd5, 5'd6);
      repeat (20) tick_w(1'b1);
      chk(rd_cnt == rc0 && wr_cnt == wc0, "R8 invalid opcode no access", rd_cnt + wr_cnt, rc0 + wc0);
      tick_r(o, oe);
      chk(o == 0 && oe == 0, "R8/R9 idle after invalid opcode", {o, oe}, 0);
      do_read(1, 0, 5'd7, 5'd6);
    end

    // R9: read tick in the middle of a write frame aborts it.
    wc0 = wr_cnt;
    send_hdr(1, 0, 2'b01, 5'd2, 5'd8);
    tick_w(1'b1);
    tick_r(o, oe);
    chk(o == 0 && oe == 0, "R9 read tick outside read drives 0", {o, oe}, 0);
    repeat (17) tick_w(1'b1);
    @(negedge clk);
    chk(wr_cnt == wc0, "R9 aborted write not issued", wr_cnt, wc0);
    do_read(1, 0, 5'd2, 5'd8);

    // R10: write tick during read data aborts the read.
    send_hdr(1, 0, 2'b10, 5'd2, 5'd3);
    tick_r(o, oe);
    for (int i = 0; i < 5; i++) tick_r(o, oe);
    chk(oe == 1'b1, "R10 oe high before abort", oe, 1);
    tick_w(1'b1);
    chk(mdio_oe == 1'b0, "R10 oe dropped by write tick", mdio_oe, 0);
    tick_r(o, oe);
    chk(o == 0 && oe == 0, "R10 slave idle after abort", {o, oe}, 0);
    do_read(1, 0, 5'd2, 5'd3);

    // R1: reset during read data phase.
    send_hdr(1, 0, 2'b10, 5'd0, 5'd12);
    tick_r(o, oe);
    tick_r(o, oe);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(mdio_oe == 0 && mdio_o == 0, "R1 reset mid-frame releases line", {mdio_o, mdio_oe}, 0);
    tick_r(o, oe);
    chk(o == 0 && oe == 0, "R1 idle after reset", {o, oe}, 0);
    do_read(1, 0, 5'd0, 5'd12);

    // Constrained random frames.
    for (int n = 0; n < 60; n++) begin
      logic [4:0]  ra, phy;
      logic [15:0] d;
      int          pre;
      ra  = 5'($urandom_range(0, 31));
      phy = 5'($urandom_range(0, 31));
      d   = 16'($urandom);
      pre = $urandom_range(0, 4);
      if ($urandom_range(0, 1) == 1)
        do_write(pre, phy, ra, d, 2'($urandom));
      else
        do_read(pre, $urandom_range(0, 2), phy, ra);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule